// File: doc/BRIEF.md
# Column-to-Row Packet Spacing Monitor

This block watches the two command streams of a packetized, multi-bank DRAM bus: the column stream, which carries reads and writes, and the row stream, which carries activates and precharges. Every row packet is judged against the column activity recorded for the same device. The block flags a row packet that is not allowed at all, a precharge that comes sooner than the read or write-retire spacing permits, and a precharge that would close a bank while a write to it still waits in the write buffer.

For each device the monitor keeps the bank of the last read and a countdown of the spacing still owed, the bank of the last write-buffer retire with its own countdown, a pending-write flag with its bank, and the bank left open by the last read or write. A per-device retire strobe tells the monitor when the write buffer of that device has drained. For every row packet the result appears one clock later as a valid pulse, a two-bit code and the spacing rule that was applied. It is meant for use as a protocol monitor next to a memory controller or in a verification environment.

Top module: `colrow_gap_monitor`

## Requirements
- R1: One clock after each accepted row packet (`row_valid` high), `chk_valid` is high for exactly one cycle with the result. After reset, and in any cycle that follows a cycle with no row packet, `chk_valid`, `chk_code` and `chk_gap` are all zero. Result codes are 0 ok, 1 too-early, 2 illegal and 3 hazardous.
- R2: The column opcodes are 0 no-op, 1 read, 2 write, 3 column-precharge, 4 read-with-precharge and 5 write-with-precharge. Codes 3, 6 and 7 act as a column no-op, 4 acts as read and 5 acts as write. The row opcodes are 0 no-op, 1 activate, 2 precharge, 3 refresh-activate (acts as activate) and 4 refresh-precharge (acts as precharge), and codes 5 to 7 act as no-op. A row no-op, a row packet after only column no-ops, or a row packet to a device other than that of the column activity gives code 0 with gap 0.
- R3: A row bank interacts with a recorded column bank only when it is equal to it or exactly one above or below it. The arithmetic does not wrap, so bank 0 and bank NUM_BANK-1 are not neighbours. A row packet to any other bank gives code 0 and gap 0.
- R4: An activate or refresh-activate to the same or an adjacent bank of the bank opened by the last read or write on that device gives code 2, with gap 0. The open mark is removed when a precharge or refresh-precharge targets exactly that bank on that device.
- R5: A precharge or refresh-precharge to the same or an adjacent bank of the last read on that device gives code 1 when it comes fewer than T_RDP cycles after the read, and code 0 otherwise. In both cases the gap is T_RDP.
- R6: A precharge or refresh-precharge to the same or an adjacent bank of the last retired write gives code 1 when it comes fewer than T_RTP cycles after the retire, and code 0 otherwise. In both cases the gap is T_RTP. When both R5 and R6 match, the larger spacing is reported.
- R7: A precharge or refresh-precharge to the same or an adjacent bank of a pending, unretired write on that device gives code 3. This takes precedence over code 1, and the gap is still reported as in R5 and R6.
- R8: A write sets the device's pending flag and the retire strobe clears it. A retire that arrives while no write is pending does nothing: it starts no T_RTP window.
- R9: A column packet or a retire strobe in the same cycle as a row packet counts as happening before the row packet with zero elapsed cycles. A read plus a precharge gives code 1, a write plus a precharge gives code 3, a retire plus a precharge gives code 1 with gap T_RTP, and a read or write plus an activate gives code 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| col_valid | input | 1 | Column packet present |
| col_op | input | 3 | Column opcode (R2) |
| col_dev | input | $clog2(NUM_DEV) | Column target device |
| col_bank | input | $clog2(NUM_BANK) | Column target bank |
| row_valid | input | 1 | Row packet present |
| row_op | input | 3 | Row opcode (R2) |
| row_dev | input | $clog2(NUM_DEV) | Row target device |
| row_bank | input | $clog2(NUM_BANK) | Row target bank |
| retire | input | NUM_DEV | Per-device write-buffer retire strobe |
| chk_valid | output | 1 | Result pulse, one cycle after the row packet |
| chk_code | output | 2 | Result code |
| chk_gap | output | $clog2(max(T_RDP,T_RTP)+1) | Spacing rule applied, in cycles |

## Verification
Two of the block's functions can land in the same cycle. The first is the update of the per-device records, from a column packet or a retire strobe. The second is the judgment of a row packet against those records. The bench provokes this by driving a read, a write, or a retire on the same cycle as a precharge or activate to the same device and bank. The result is judged against the rule that the column event or retire counts as already done with zero cycles elapsed: the outcome must be too-early, hazardous or illegal, never ok.

// File: rtl/colrow_gap_monitor.sv
module colrow_gap_monitor #(
  parameter int NUM_DEV  = 4,
  parameter int NUM_BANK = 16,
  parameter int T_RDP    = 4,
  parameter int T_RTP    = 8,
  localparam int DW = $clog2(NUM_DEV),
  localparam int BW = $clog2(NUM_BANK),
  localparam int LW = $clog2(((T_RDP > T_RTP) ? T_RDP : T_RTP) + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               col_valid,
  input  logic [2:0]         col_op,
  input  logic [DW-1:0]      col_dev,
  input  logic [BW-1:0]      col_bank,
  input  logic               row_valid,
  input  logic [2:0]         row_op,
  input  logic [DW-1:0]      row_dev,
  input  logic [BW-1:0]      row_bank,
  input  logic [NUM_DEV-1:0] retire,
  output logic               chk_valid,
  output logic [1:0]         chk_code,
  output logic [LW-1:0]      chk_gap
);
  localparam logic [LW-1:0] RDP_L = LW'(T_RDP);
  localparam logic [LW-1:0] RTP_L = LW'(T_RTP);

  function automatic logic near(input logic [BW-1:0] a, input logic [BW-1:0] b);
    return (a == b) || ({1'b0, a} == {1'b0, b} + {{BW{1'b0}}, 1'b1})
                    || ({1'b0, b} == {1'b0, a} + {{BW{1'b0}}, 1'b1});
  endfunction

  logic col_rd, col_wr, row_act, row_pre;
  assign col_rd  = col_valid && (col_op == 3'd1 || col_op == 3'd4);
  assign col_wr  = col_valid && (col_op == 3'd2 || col_op == 3'd5);
  assign row_act = row_valid && (row_op == 3'd1 || row_op == 3'd3);
  assign row_pre = row_valid && (row_op == 3'd2 || row_op == 3'd4);

  logic [NUM_DEV-1:0] rd_vld, rt_vld, pend, opn;
  logic [BW-1:0]      rd_bank [NUM_DEV];
  logic [BW-1:0]      rt_bank [NUM_DEV];
  logic [BW-1:0]      pd_bank [NUM_DEV];
  logic [BW-1:0]      op_bank [NUM_DEV];
  logic [LW-1:0]      rd_left [NUM_DEV];
  logic [LW-1:0]      rt_left [NUM_DEV];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld <= '0; rt_vld <= '0; pend <= '0; opn <= '0;
      for (int d = 0; d < NUM_DEV; d++) begin
        rd_bank[d] <= '0; rt_bank[d] <= '0; pd_bank[d] <= '0; op_bank[d] <= '0;
        rd_left[d] <= '0; rt_left[d] <= '0;
      end
    end else begin
      for (int d = 0; d < NUM_DEV; d++) begin
        if (col_rd && col_dev == DW'(d)) begin
          rd_vld[d] <= 1'b1; rd_bank[d] <= col_bank; rd_left[d] <= RDP_L - 1'b1;
        end else if (rd_left[d] != '0) begin
          rd_left[d] <= rd_left[d] - 1'b1;
        end
        if (retire[d] && pend[d]) begin
          rt_vld[d] <= 1'b1; rt_bank[d] <= pd_bank[d]; rt_left[d] <= RTP_L - 1'b1;
        end else if (rt_left[d] != '0) begin
          rt_left[d] <= rt_left[d] - 1'b1;
        end
        if (col_wr && col_dev == DW'(d)) begin
          pend[d] <= 1'b1; pd_bank[d] <= col_bank;
        end else if (retire[d]) begin
          pend[d] <= 1'b0;
        end
        if ((col_rd || col_wr) && col_dev == DW'(d)) begin
          opn[d] <= 1'b1; op_bank[d] <= col_bank;
        end else if (row_pre && row_dev == DW'(d) && row_bank == op_bank[d]) begin
          opn[d] <= 1'b0;
        end
      end
    end
  end

  logic          c_here, rt_now, c_rd, c_wr;
  logic          v_rd, v_rt, v_pd, v_op;
  logic [BW-1:0] b_rd, b_rt, b_pd, b_op;
  logic [LW-1:0] l_rd, l_rt;
  assign c_here = col_dev == row_dev;
  assign c_rd   = col_rd && c_here;
  assign c_wr   = col_wr && c_here;
  assign rt_now = retire[row_dev] && pend[row_dev];

  assign v_rd = rd_vld[row_dev] || c_rd;
  assign b_rd = c_rd ? col_bank : rd_bank[row_dev];
  assign l_rd = c_rd ? RDP_L : rd_left[row_dev];
  assign v_rt = rt_vld[row_dev] || rt_now;
  assign b_rt = rt_now ? pd_bank[row_dev] : rt_bank[row_dev];
  assign l_rt = rt_now ? RTP_L : rt_left[row_dev];
  assign v_pd = (pend[row_dev] && !retire[row_dev]) || c_wr;
  assign b_pd = c_wr ? col_bank : pd_bank[row_dev];
  assign v_op = opn[row_dev] || c_rd || c_wr;
  assign b_op = (c_rd || c_wr) ? col_bank : op_bank[row_dev];

  logic          m_rd, m_rt;
  logic [LW-1:0] g_rd, g_rt;
  logic [1:0]    code_n;
  assign m_rd = row_pre && v_rd && near(b_rd, row_bank);
  assign m_rt = row_pre && v_rt && near(b_rt, row_bank);
  assign g_rd = m_rd ? RDP_L : '0;
  assign g_rt = m_rt ? RTP_L : '0;

  always_comb begin
    code_n = 2'd0;
    if (row_act && v_op && near(b_op, row_bank))                   code_n = 2'd2;
    else if (row_pre && v_pd && near(b_pd, row_bank))              code_n = 2'd3;
    else if ((m_rd && l_rd != '0) || (m_rt && l_rt != '0))         code_n = 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_valid <= 1'b0; chk_code <= 2'd0; chk_gap <= '0;
    end else begin
      chk_valid <= row_valid;
      chk_code  <= row_valid ? code_n : 2'd0;
      chk_gap   <= row_valid ? ((g_rd > g_rt) ? g_rd : g_rt) : '0;
    end
  end
endmodule

// File: rtl/colrow_gap_monitor_chk.sv
module colrow_gap_monitor_chk #(
  parameter int T_RDP = 4,
  parameter int T_RTP = 8,
  parameter int GW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          row_valid,
  input logic [2:0]    row_op,
  input logic          chk_valid,
  input logic [1:0]    chk_code,
  input logic [GW-1:0] chk_gap
);
  a_r1_pulse_follows_row: assert property (@(posedge clk) disable iff (!rst_n)
    row_valid |=> chk_valid);
  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !row_valid |=> (!chk_valid && chk_code == 2'd0 && chk_gap == '0));
  a_r2_row_nop_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (row_valid && (row_op == 3'd0 || row_op > 3'd4)) |=> (chk_code == 2'd0 && chk_gap == '0));
  a_r4_act_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (row_valid && (row_op == 3'd1 || row_op == 3'd3)) |=>
      (chk_gap == '0 && (chk_code == 2'd0 || chk_code == 2'd2)));
  a_r6_pre_gap_set: assert property (@(posedge clk) disable iff (!rst_n)
    (row_valid && (row_op == 3'd2 || row_op == 3'd4)) |=>
      (chk_code != 2'd2 && (chk_gap == '0 || chk_gap == GW'(T_RDP) || chk_gap == GW'(T_RTP))));
endmodule

bind colrow_gap_monitor colrow_gap_monitor_chk #(.T_RDP(T_RDP), .T_RTP(T_RTP), .GW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .row_valid(row_valid), .row_op(row_op),
  .chk_valid(chk_valid), .chk_code(chk_code), .chk_gap(chk_gap)
);

// File: tb/colrow_gap_monitor_tb.sv
`timescale 1ns/1ps
module colrow_gap_monitor_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       col_valid, row_valid;
  logic [2:0] col_op, row_op;
  logic [1:0] col_dev, row_dev;
  logic [3:0] col_bank, row_bank;
  logic [3:0] retire;
  logic       chk_valid;
  logic [1:0] chk_code;
  logic [3:0] chk_gap;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  colrow_gap_monitor u_dut (
    .clk(clk), .rst_n(rst_n),
    .col_valid(col_valid), .col_op(col_op), .col_dev(col_dev), .col_bank(col_bank),
    .row_valid(row_valid), .row_op(row_op), .row_dev(row_dev), .row_bank(row_bank),
    .retire(retire), .chk_valid(chk_valid), .chk_code(chk_code), .chk_gap(chk_gap)
  );

  task automatic step(input logic cv, input logic [2:0] cop, input logic [1:0] cd, input logic [3:0] cb,
                      input logic rv, input logic [2:0] rop, input logic [1:0] rd, input logic [3:0] rb,
                      input logic [3:0] ret);
    col_valid = cv; col_op = cop; col_dev = cd; col_bank = cb;
    row_valid = rv; row_op = rop; row_dev = rd; row_bank = rb; retire = ret;
    @(negedge clk);
    col_valid = 0; row_valid = 0; retire = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic col(input logic [2:0] op, input logic [1:0] d, input logic [3:0] b);
    step(1, op, d, b, 0, 0, 0, 0, 0);
  endtask

  task automatic row(input logic [2:0] op, input logic [1:0] d, input logic [3:0] b);
    step(0, 0, 0, 0, 1, op, d, b, 0);
  endtask

  task automatic expect_res(input string req, input logic [1:0] code, input logic [3:0] gap);
    checks++;
    if (chk_valid !== 1'b1 || chk_code !== code || chk_gap !== gap) begin
      errors++;
      $display("FAIL %s: valid=%0b code=%0d gap=%0d, expected valid=1 code=%0d gap=%0d",
               req, chk_valid, chk_code, chk_gap, code, gap);
    end
  endtask

  task automatic do_reset;
    rst_n = 0; col_valid = 0; row_valid = 0; retire = 0;
    col_op = 0; col_dev = 0; col_bank = 0; row_op = 0; row_dev = 0; row_bank = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset();
    idle(1);
    checks++;
    if (chk_valid !== 0 || chk_code !== 0 || chk_gap !== 0) begin
      errors++;
      $display("FAIL R1: valid=%0b code=%0d gap=%0d, expected all zero", chk_valid, chk_code, chk_gap);
    end
    row(3'd0, 0, 0);
    expect_res("R1 pulse after row", 0, 0);
    idle(1);
    checks++;
    if (chk_valid !== 0) begin
      errors++;
      $display("FAIL R1: valid=%0b, expected 0 one cycle later", chk_valid);
    end
  endtask

  task automatic t_nop;
    do_reset();
    col(3'd3, 0, 3); row(3'd1, 0, 3);
    expect_res("R2 column-precharge acts as no-op", 0, 0);
    col(3'd0, 0, 4); row(3'd2, 0, 4);
    expect_res("R2 column no-op", 0, 0);
    col(3'd1, 0, 5); row(3'd1, 1, 5);
    expect_res("R2 other device activate", 0, 0);
    row(3'd2, 2, 5);
    expect_res("R2 other device precharge", 0, 0);
    row(3'd0, 0, 5);
    expect_res("R2 row no-op", 0, 0);
  endtask

  task automatic t_far;
    do_reset();
    col(3'd1, 0, 5); row(3'd1, 0, 7);
    expect_res("R3 two banks apart", 0, 0);
    row(3'd2, 0, 3);
    expect_res("R3 precharge two banks below", 0, 0);
    do_reset();
    col(3'd1, 0, 0); row(3'd1, 0, 15);
    expect_res("R3 bank 0 vs 15 no wrap", 0, 0);
    col(3'd2, 1, 15); row(3'd2, 1, 0);
    expect_res("R3 bank 15 vs 0 no wrap", 0, 0);
  endtask

  task automatic t_act;
    do_reset();
    col(3'd1, 2, 6); row(3'd1, 2, 6);
    expect_res("R4 activate same bank", 2, 0);
    row(3'd3, 2, 7);
    expect_res("R4 refresh-activate adjacent bank", 2, 0);
    row(3'd2, 2, 6);
    row(3'd1, 2, 5);
    expect_res("R4 activate after precharge", 0, 0);
    col(3'd5, 1, 2); row(3'd1, 1, 1);
    expect_res("R4 write-with-precharge acts as write", 2, 0);
  endtask

  task automatic t_rdp;
    do_reset();
    col(3'd1, 1, 4); idle(2); row(3'd2, 1, 4);
    expect_res("R5 precharge 3 cycles after read", 1, 4);
    do_reset();
    col(3'd1, 1, 4); idle(3); row(3'd2, 1, 5);
    expect_res("R5 precharge 4 cycles after read", 0, 4);
    do_reset();
    col(3'd1, 1, 4); row(3'd4, 1, 3);
    expect_res("R5 refresh-precharge 1 cycle after read", 1, 4);
    do_reset();
    col(3'd4, 3, 8); idle(1); row(3'd2, 3, 8);
    expect_res("R5 read-with-precharge acts as read", 1, 4);
  endtask

  task automatic t_rtp;
    do_reset();
    col(3'd2, 3, 9); step(0, 0, 0, 0, 0, 0, 0, 0, 4'b1000); idle(6); row(3'd2, 3, 9);
    expect_res("R6 precharge 7 cycles after retire", 1, 8);
    do_reset();
    col(3'd2, 3, 9); step(0, 0, 0, 0, 0, 0, 0, 0, 4'b1000); idle(7); row(3'd2, 3, 10);
    expect_res("R6 precharge 8 cycles after retire", 0, 8);
  endtask

  task automatic t_haz;
    do_reset();
    col(3'd2, 0, 2); row(3'd2, 0, 3);
    expect_res("R7 precharge adjacent pending write", 3, 0);
    do_reset();
    col(3'd1, 0, 2); col(3'd2, 0, 2); row(3'd2, 0, 2);
    expect_res("R7 hazard over too-early", 3, 4);
  endtask

  task automatic t_retire;
    do_reset();
    step(0, 0, 0, 0, 0, 0, 0, 0, 4'b0010); row(3'd2, 1, 0);
    expect_res("R8 retire without pending write ignored", 0, 0);
    col(3'd2, 1, 4); step(0, 0, 0, 0, 0, 0, 0, 0, 4'b0010); idle(7); row(3'd2, 1, 4);
    expect_res("R8 retire clears pending", 0, 8);
  endtask

  task automatic t_same;
    do_reset();
    step(1, 3'd1, 2, 10, 1, 3'd2, 2, 10, 0);
    expect_res("R9 read and precharge same cycle", 1, 4);
    do_reset();
    step(1, 3'd2, 2, 11, 1, 3'd2, 2, 11, 0);
    expect_res("R9 write and precharge same cycle", 3, 0);
    do_reset();
    col(3'd2, 0, 1); idle(1);
    step(0, 0, 0, 0, 1, 3'd2, 0, 1, 4'b0001);
    expect_res("R9 retire and precharge same cycle", 1, 8);
    do_reset();
    step(1, 3'd1, 1, 7, 1, 3'd1, 1, 7, 0);
    expect_res("R9 read and activate same cycle", 2, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_nop();
    t_far();
    t_act();
    t_rdp();
    t_rtp();
    t_haz();
    t_retire();
    t_same();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule